// File: doc/BRIEF.md
# Expanded-Range Iterative Hyperbolic CORDIC

This block computes hyperbolic functions with a multi-cycle, word-parallel CORDIC engine. The usual hyperbolic CORDIC only converges when the angle magnitude stays below about 1.1. To widen that range, the engine runs a short series of extra "negative-index" micro-rotations before the normal ones. Each extra step scales the cross term by (1 − 2^-(j+2)) and has its own arctanh angle table. With M_EXP = 5 the rotation domain grows to roughly ±12.4, and with M_EXP = 0 it is roughly ±2.09.

A one-cycle `start` does two things when the engine is idle: it captures the three n-bit two's-complement inputs, and it captures a mode bit that selects rotation or vectoring. The sequencer then walks the iteration schedule one step per clock:

- first the expansion steps, from j = M_EXP down to 0;
- then the basic steps, i = 1..N_BASIC, with the mandatory repeats.

After the last step the three results are written to n-bit outputs with the guard bits truncated, and `done` pulses for one cycle.

Gain compensation is left to the caller. In rotation mode, feeding X0 = 1/An and Y0 = 0 yields cosh and sinh of Z0. In vectoring mode, Z0 = 0 yields atanh(Y0/X0).

Top module: `hcordic_engine`

## Requirements
- R1: When `start` is high and the engine is idle, the inputs and the mode are captured: `mode` = 0 selects rotation and `mode` = 1 selects vectoring. Inputs are two's complement with FRAC fractional bits. Internally they are extended by GUARD = log2(IO_W) low guard bits and HEAD sign bits of headroom.
- R2: Expansion steps run first, for j = M_EXP down to 0. Each step computes X' = X + d·(Y − (Y>>>(j+2))), Y' = Y + d·(X − (X>>>(j+2))) and Z' = Z − d·atanh(1 − 2^-(j+2)). With M_EXP = 1 this lets rotation converge for |Z0| up to about 3.44.
- R3: Basic steps i = 1..N_BASIC follow. Each computes X' = X + d·(X-shifted Y, i.e. Y>>>i), Y' = Y + d·(X>>>i) and Z' = Z − d·atanh(2^-i). Both angle sets come from two separate constant tables.
- R4: Basic indices 4, 13, 40, … (each next index is 3k+1) are executed twice. The count v of such indices that are ≤ N_BASIC is part of the latency.
- R5: In rotation, d = −1 when Z < 0, else +1. In vectoring, d = −1 when X·Y ≥ 0 (either operand zero, or equal signs), else +1.
- R6: `done` goes high exactly M_EXP+1+N_BASIC+v cycles after the accepting `start` edge and lasts exactly one cycle.
- R7: A `start` seen while an operation is running is ignored. The running operation's timing and results are unchanged.
- R8: The outputs carry the internal results with guard bits and headroom dropped. They change only together with `done` and hold until the next result.
- R9: In rotation with X0 = 1/An, Y0 = 0, the outputs give X ≈ cosh Z0, Y ≈ sinh Z0 and Z ≈ 0, within 6 LSB, where An is the total step gain. With a general Y0 they give X ≈ An(X0·cosh Z0 + Y0·sinh Z0) and Y ≈ An(Y0·cosh Z0 + X0·sinh Z0).
- R10: In vectoring with Z0 = 0, the outputs give Z ≈ atanh(Y0/X0), Y ≈ 0 and X ≈ An·sqrt(X0² − Y0²), within 6 LSB.
- R11: While reset is high, `done` is low and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (honoured only when idle) |
| mode | input | 1 | 0 = rotation, 1 = vectoring |
| x_in | input | IO_W | Initial X, two's complement, FRAC fraction bits |
| y_in | input | IO_W | Initial Y |
| z_in | input | IO_W | Initial Z (angle) |
| x_out | output | IO_W | Final X |
| y_out | output | IO_W | Final Y |
| z_out | output | IO_W | Final Z |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
The bench builds the engine with IO_W = 16, FRAC = 11, HEAD = 4, M_EXP = 1 and N_BASIC = 14. With these values the schedule has two repeats (indices 4 and 13), so the run is 18 steps long. M_EXP = 1 keeps 1/An (about 3.77) inside the 16-bit input format. It also pushes rotation angles (±2.8, 3.3) and vectoring ratios (0.99) past what M_EXP = 0 could reach, so the expansion steps are needed to meet the tolerance. Small angles, an off-axis Y0, a zero-Y vectoring input and a mid-run restart exercise the direction rule and the busy guard.

// File: rtl/hcordic_pkg.sv
package hcordic_pkg;

    typedef enum logic {
        HC_ROT = 1'b0,
        HC_VEC = 1'b1
    } hc_mode_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_EXPAND = 2'd1,
        PH_BASIC  = 2'd2
    } hc_phase_e;

    // Number of basic indices k <= n in the chain 4, 13, 40, ... (k -> 3k+1).
    function automatic int hc_repeat_count(input int n);
        int k;
        int c;
        k = 4;
        c = 0;
        while (k <= n) begin
            c = c + 1;
            k = 3 * k + 1;
        end
        return c;
    endfunction

    function automatic real hc_pow2(input int e);
        real p;
        p = 1.0;
        for (int q = 0; q < e; q++) p = p * 2.0;
        return p;
    endfunction

    // atanh(1 - 2^-(j+2)) = 0.5*ln(2^(j+3) - 1), rounded to frac bits.
    function automatic longint hc_expand_angle(input int j, input int frac);
        real a;
        a = 0.5 * $ln(hc_pow2(j + 3) - 1.0);
        return longint'($rtoi(a * hc_pow2(frac) + 0.5));
    endfunction

    // atanh(2^-i) = 0.5*ln((2^i+1)/(2^i-1)), rounded to frac bits.
    function automatic longint hc_basic_angle(input int i, input int frac);
        real p;
        real a;
        p = hc_pow2(i);
        a = 0.5 * $ln((p + 1.0) / (p - 1.0));
        return longint'($rtoi(a * hc_pow2(frac) + 0.5));
    endfunction

endpackage

// File: rtl/hcordic_angle_rom.sv
module hcordic_angle_rom
    import hcordic_pkg::*;
#(
    parameter int W         = 24,
    parameter int AFRAC     = 15,
    parameter int IDX_W     = 4,
    parameter int LAST_IDX  = 5,
    parameter bit EXPANSION = 1'b1
) (
    input  logic [IDX_W-1:0] idx,
    output logic [W-1:0]     angle
);
    localparam int SIZE = 1 << IDX_W;

    logic [W-1:0] tbl [SIZE];

    for (genvar g = 0; g < SIZE; g++) begin : g_ent
        if (g > LAST_IDX) begin : g_pad
            assign tbl[g] = '0;
        end else if (EXPANSION) begin : g_exp
            localparam logic [W-1:0] A = W'(hc_expand_angle(g, AFRAC));
            assign tbl[g] = A;
        end else if (g == 0) begin : g_zero
            assign tbl[g] = '0;
        end else begin : g_bas
            localparam logic [W-1:0] A = W'(hc_basic_angle(g, AFRAC));
            assign tbl[g] = A;
        end
    end

    assign angle = tbl[idx];
endmodule

// File: rtl/hcordic_seq.sv
module hcordic_seq
    import hcordic_pkg::*;
#(
    parameter int M_EXP   = 5,
    parameter int N_BASIC = 14,
    parameter int JW      = 4,
    parameter int RW      = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          accept,
    output logic          busy,
    output logic          expand,
    output logic          last,
    output logic [JW-1:0] j_idx,
    output logic [RW-1:0] i_idx
);
    hc_phase_e     phase;
    logic [JW-1:0] j_q;
    logic [RW-1:0] i_q;
    logic [RW-1:0] rep_q;
    logic          seen_q;
    logic          dup;

    assign accept = start && (phase == PH_IDLE);
    assign busy   = (phase != PH_IDLE);
    assign expand = (phase == PH_EXPAND);
    assign dup    = (i_q == rep_q) && !seen_q;
    assign last   = (phase == PH_BASIC) && (i_q == RW'(N_BASIC)) && !dup;
    assign j_idx  = j_q;
    assign i_idx  = i_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            j_q    <= '0;
            i_q    <= '0;
            rep_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase  <= PH_EXPAND;
                        j_q    <= JW'(M_EXP);
                        i_q    <= RW'(1);
                        rep_q  <= RW'(4);
                        seen_q <= 1'b0;
                    end
                end
                PH_EXPAND: begin
                    if (j_q == '0) phase <= PH_BASIC;
                    else           j_q   <= j_q - JW'(1);
                end
                PH_BASIC: begin
                    if (last) begin
                        phase <= PH_IDLE;
                    end else if (dup) begin
                        seen_q <= 1'b1;
                    end else begin
                        if (i_q == rep_q) begin
                            rep_q  <= (rep_q << 1) + rep_q + RW'(1);
                            seen_q <= 1'b0;
                        end
                        i_q <= i_q + RW'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hcordic_dp.sv
module hcordic_dp
    import hcordic_pkg::*;
#(
    parameter int IO_W = 16,
    parameter int G    = 4,
    parameter int HEAD = 4,
    parameter int SW   = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            step_en,
    input  logic            last,
    input  logic            expand,
    input  hc_mode_e        mode_in,
    input  logic [SW-1:0]   shamt,
    input  logic [IO_W+G+HEAD-1:0] ang_exp,
    input  logic [IO_W+G+HEAD-1:0] ang_bas,
    input  logic [IO_W-1:0] x0,
    input  logic [IO_W-1:0] y0,
    input  logic [IO_W-1:0] z0,
    output logic [IO_W-1:0] x_res,
    output logic [IO_W-1:0] y_res,
    output logic [IO_W-1:0] z_res,
    output logic            done
);
    localparam int W = IO_W + G + HEAD;

    hc_mode_e             mode_q;
    logic signed [W-1:0]  x_q, y_q, z_q;
    logic signed [W-1:0]  ax, ay, ang;
    logic signed [W-1:0]  xn, yn, zn;
    logic                 neg;

    function automatic logic signed [W-1:0] widen(input logic [IO_W-1:0] v);
        return {{HEAD{v[IO_W-1]}}, v, {G{1'b0}}};
    endfunction

    always_comb begin
        ax  = expand ? (y_q - (y_q >>> shamt)) : (y_q >>> shamt);
        ay  = expand ? (x_q - (x_q >>> shamt)) : (x_q >>> shamt);
        ang = expand ? $signed(ang_exp) : $signed(ang_bas);
        if (mode_q == HC_ROT)
            neg = z_q[W-1];
        else
            neg = (x_q == '0) || (y_q == '0) || (x_q[W-1] == y_q[W-1]);
        xn = neg ? (x_q - ax)  : (x_q + ax);
        yn = neg ? (y_q - ay)  : (y_q + ay);
        zn = neg ? (z_q + ang) : (z_q - ang);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= HC_ROT;
            x_q    <= '0;
            y_q    <= '0;
            z_q    <= '0;
            x_res  <= '0;
            y_res  <= '0;
            z_res  <= '0;
            done   <= 1'b0;
        end else begin
            done <= step_en && last;
            if (load) begin
                mode_q <= mode_in;
                x_q    <= widen(x0);
                y_q    <= widen(y0);
                z_q    <= widen(z0);
            end else if (step_en) begin
                x_q <= xn;
                y_q <= yn;
                z_q <= zn;
                if (last) begin
                    x_res <= xn[G +: IO_W];
                    y_res <= yn[G +: IO_W];
                    z_res <= zn[G +: IO_W];
                end
            end
        end
    end
endmodule

// File: rtl/hcordic_engine.sv
module hcordic_engine
    import hcordic_pkg::*;
#(
    parameter int IO_W    = 16,
    parameter int FRAC    = 11,
    parameter int HEAD    = 4,
    parameter int M_EXP   = 5,
    parameter int N_BASIC = 14
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            mode,
    input  logic [IO_W-1:0] x_in,
    input  logic [IO_W-1:0] y_in,
    input  logic [IO_W-1:0] z_in,
    output logic [IO_W-1:0] x_out,
    output logic [IO_W-1:0] y_out,
    output logic [IO_W-1:0] z_out,
    output logic            done
);
    localparam int GUARD = $clog2(IO_W);
    localparam int W     = IO_W + GUARD + HEAD;
    localparam int AFRAC = FRAC + GUARD;
    localparam int JW    = $clog2(M_EXP + 1) + 1;
    localparam int RW    = $clog2(3 * N_BASIC + 2) + 1;
    localparam int SW    = ((JW > RW) ? JW : RW) + 1;
    localparam int TOTAL = M_EXP + 1 + N_BASIC + hc_repeat_count(N_BASIC);

    logic          accept, busy, expand, last;
    logic [JW-1:0] j_idx;
    logic [RW-1:0] i_idx;
    logic [SW-1:0] shamt;
    logic [W-1:0]  ang_exp, ang_bas;

    hcordic_seq #(
        .M_EXP(M_EXP), .N_BASIC(N_BASIC), .JW(JW), .RW(RW)
    ) u_seq (
        .clk(clk), .rst(rst), .start(start), .accept(accept), .busy(busy),
        .expand(expand), .last(last), .j_idx(j_idx), .i_idx(i_idx)
    );

    hcordic_angle_rom #(
        .W(W), .AFRAC(AFRAC), .IDX_W(JW), .LAST_IDX(M_EXP), .EXPANSION(1'b1)
    ) u_rom_exp (
        .idx(j_idx), .angle(ang_exp)
    );

    hcordic_angle_rom #(
        .W(W), .AFRAC(AFRAC), .IDX_W(RW), .LAST_IDX(N_BASIC), .EXPANSION(1'b0)
    ) u_rom_bas (
        .idx(i_idx), .angle(ang_bas)
    );

    assign shamt = expand ? (SW'(j_idx) + SW'(2)) : SW'(i_idx);

    hcordic_dp #(
        .IO_W(IO_W), .G(GUARD), .HEAD(HEAD), .SW(SW)
    ) u_dp (
        .clk(clk), .rst(rst), .load(accept), .step_en(busy), .last(last),
        .expand(expand), .mode_in(hc_mode_e'(mode)), .shamt(shamt),
        .ang_exp(ang_exp), .ang_bas(ang_bas),
        .x0(x_in), .y0(y_in), .z0(z_in),
        .x_res(x_out), .y_res(y_out), .z_res(z_out), .done(done)
    );
endmodule

// File: rtl/hcordic_checker.sv
module hcordic_checker #(
    parameter int IO_W  = 16,
    parameter int TOTAL = 22
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic [IO_W-1:0] x_out,
    input logic [IO_W-1:0] y_out,
    input logic [IO_W-1:0] z_out
);
    int run_cnt;

    always_ff @(posedge clk) begin
        if (rst)                run_cnt <= 0;
        else if (start && !busy) run_cnt <= 0;
        else                    run_cnt <= run_cnt + 1;
    end

    a_r6_single_done: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6 latency; R4 repeats are part of TOTAL; R7 a restart would shift it.
    a_r6_latency: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_cnt == TOTAL));

    a_r7_idle_at_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(x_out) && $stable(y_out) && $stable(z_out)));
endmodule

bind hcordic_engine hcordic_checker #(.IO_W(IO_W), .TOTAL(TOTAL)) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .x_out(x_out), .y_out(y_out), .z_out(z_out)
);

// File: tb/tb_hcordic_engine.sv
module tb_hcordic_engine;
    localparam int IO_W = 16;
    localparam int FR   = 11;
    localparam int MT   = 1;
    localparam int NT   = 14;
    localparam int TOL  = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic mode = 1'b0;
    logic [IO_W-1:0] x_in = '0, y_in = '0, z_in = '0;
    logic [IO_W-1:0] x_out, y_out, z_out;
    logic done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int steps;
    real an;

    typedef struct {
        int    ex, ey, ez;
        int    due;
        string tag;
    } exp_t;
    exp_t sb[$];
    int last_x, last_y, last_z;
    logic done_prev = 1'b0;

    hcordic_engine #(.IO_W(IO_W), .FRAC(FR), .HEAD(4), .M_EXP(MT), .N_BASIC(NT)) dut (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .x_in(x_in), .y_in(y_in), .z_in(z_in),
        .x_out(x_out), .y_out(y_out), .z_out(z_out), .done(done)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int to_code(input real v);
        return $rtoi(v * 2048.0 + ((v >= 0.0) ? 0.5 : -0.5));
    endfunction

    task automatic check(input string req, input string what, input int act, input int expv, input int tol);
        int diff;
        checks++;
        diff = act - expv;
        if (diff < 0) diff = -diff;
        if (diff > tol) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Monitor: pops the scoreboard whenever a result appears.
    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                if (sb.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R6 unexpected done actual=1 expected=0");
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check("R4 R6", "done cycle", cyc, e.due, 0);
                    check(e.tag, "x", $signed(x_out), e.ex, TOL);
                    check(e.tag, "y", $signed(y_out), e.ey, TOL);
                    check(e.tag, "z", $signed(z_out), e.ez, TOL);
                end
                last_x = $signed(x_out);
                last_y = $signed(y_out);
                last_z = $signed(z_out);
                check("R6", "done width", int'(done_prev), 0, 0);
            end
            done_prev <= done;
        end
    end

    task automatic run_op(input bit md, input real xr, input real yr, input real zr,
                          input string tag, input bit poke);
        int xc, yc, zc;
        real xq, yq, zq, ch, sh;
        exp_t e;
        xc = to_code(xr); yc = to_code(yr); zc = to_code(zr);
        xq = xc / 2048.0; yq = yc / 2048.0; zq = zc / 2048.0;
        if (!md) begin
            ch = ($exp(zq) + $exp(-zq)) / 2.0;
            sh = ($exp(zq) - $exp(-zq)) / 2.0;
            e.ex = to_code(an * (xq * ch + yq * sh));
            e.ey = to_code(an * (yq * ch + xq * sh));
            e.ez = 0;
        end else begin
            e.ex = to_code(an * $sqrt(xq * xq - yq * yq));
            e.ey = 0;
            e.ez = to_code(zq + 0.5 * $ln((xq + yq) / (xq - yq)));
        end
        e.tag = tag;
        @(negedge clk);
        mode = md; x_in = 16'(xc); y_in = 16'(yc); z_in = 16'(zc); start = 1'b1;
        e.due = cyc + 1 + steps;
        sb.push_back(e);
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (5) @(negedge clk);
            mode = ~md; x_in = 16'h1234; y_in = 16'h0777; z_in = 16'h0400; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait (sb.size() == 0);
        repeat (4) @(negedge clk);
        check("R8", "hold x", $signed(x_out), last_x, 0);
        check("R8", "hold z", $signed(z_out), last_z, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int k;
        steps = MT + 1 + NT;
        k = 4;
        while (k <= NT) begin steps++; k = 3 * k + 1; end
        an = 1.0;
        for (int j = 0; j <= MT; j++) begin
            real f;
            f = 1.0 - 1.0 / real'(1 << (j + 2));
            an = an * $sqrt(1.0 - f * f);
        end
        k = 4;
        for (int i = 1; i <= NT; i++) begin
            real f;
            f = 1.0 / real'(1 << i);
            an = an * $sqrt(1.0 - f * f);
            if (i == k) begin an = an * $sqrt(1.0 - f * f); k = 3 * k + 1; end
        end

        repeat (4) @(negedge clk);
        check("R11", "reset done", int'(done), 0, 0);
        check("R11", "reset x", int'(x_out), 0, 0);
        check("R11", "reset z", int'(z_out), 0, 0);
        rst = 1'b0;
        @(negedge clk);

        run_op(1'b0, 1.0 / an, 0.0, 0.0,  "R1 R9", 1'b0);
        run_op(1'b0, 1.0 / an, 0.0, 0.25, "R3 R9", 1'b0);
        run_op(1'b0, 1.0 / an, 0.0, 1.0,  "R9", 1'b0);
        run_op(1'b0, 1.0 / an, 0.0, -1.5, "R5 R9", 1'b0);
        run_op(1'b0, 1.0 / an, 0.0, 2.8,  "R2 R9", 1'b0);
        run_op(1'b0, 1.0 / an, 0.0, -2.8, "R7 R2", 1'b1);
        run_op(1'b0, 1.0 / an, 0.0, 3.3,  "R2 R9", 1'b0);
        run_op(1'b0, 1.0 / an, 0.5 / an, 0.7, "R9", 1'b0);
        run_op(1'b1, 1.0, 0.5,  0.0, "R1 R10", 1'b0);
        run_op(1'b1, 1.0, 0.99, 0.0, "R2 R10", 1'b0);
        run_op(1'b1, 1.5, -0.6, 0.0, "R5 R10", 1'b0);
        run_op(1'b1, 0.8, 0.0,  0.0, "R5 R10", 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule